// File: doc/BRIEF.md
# Real-Time Clock Register and Interrupt Block

This block is a memory-mapped real-time clock for a simple 32-bit word-access bus. A prescaler divides the input clock into a one-second tick, and each tick advances a 32-bit seconds counter. Software can stage a new time, and the counter takes that value at the next one-second boundary. Software can also program an alarm value, a calibration word and a control word. It can read the running count and the prescaler position.

Two independent interrupt groups report events. Each group has its own level output:

- **Clock group.** Two status bits: bit 0 is set by every one-second tick, and bit 1 is set when the count reaches the alarm value.
- **Address-error group.** One status bit, set by any access that is misaligned or hits no mapped register.

In each group, status bits are cleared by writing 1 to them. The mask register cannot be written directly. It changes only through an enable command register, which clears the mask bits set in the data, and a disable command register, which sets them.

Top module: `rtc_regblk`

Register offsets (byte addresses, word aligned):

| Offset | Name | Behaviour |
|---|---|---|
| 0x00 | time load | write stages a new time; read returns the count |
| 0x04 | time now | read returns the count |
| 0x08 | calibration | bits [20:0] read/write; bits [15:0] = cycles per second minus 1 |
| 0x0C | tick position | read-only |
| 0x10 | alarm | read/write |
| 0x14 | clock status | write 1 to clear |
| 0x18 | clock mask | read-only |
| 0x1C | clock enable | command register |
| 0x20 | clock disable | command register |
| 0x24 | error status | write 1 to clear |
| 0x28 | error mask | read-only |
| 0x2C | error enable | command register |
| 0x30 | error disable | command register |
| 0x34 | control | read/write with reserved bits |

## Requirements
- R1: After reset, the clock mask (0x18) reads 0b11, the error mask (0x28) reads 1, control (0x34) reads 0x0100_0000 and alarm (0x10) reads 0. Both interrupt outputs are low.
- R2: Clock status (0x14) bit 0 is set by each one-second tick, and bit 1 is set by the tick that brings the count to the alarm value. Writing 1 to a status bit clears it; writing 0 leaves it unchanged. Alarm (0x10) reads back the value written to it.
- R3: The clock mask ignores direct writes. A write to 0x1C clears the mask bits set in the data, and a write to 0x20 sets them. The mask changes in no other way. Both command registers read as 0.
- R4: Each interrupt output is high exactly when some status bit of its group is set and its mask bit is clear. The output reflects a status write or mask command from the clock edge that performs it.
- R5: Any access to an unmapped or misaligned address sets error status (0x24) bit 0. That bit is cleared only by writing 1 to it. The error mask (0x28) is changed through 0x2C and 0x30, and controls the error interrupt output.
- R6: With no load pending, every one-second tick increments the count by one. Between ticks the count holds. A tick happens every (calibration[15:0] + 1) clock cycles.
- R7: A write to 0x00 is applied at the first tick after the write cycle: that tick loads the written value instead of incrementing. Reads of 0x00 and of 0x04 both return the count.
- R8: Calibration (0x08) keeps only bits [20:0], and bits [31:21] read as 0. The tick position (0x0C) is a 16-bit value below calibration[15:0] + 1, and bits [31:16] read as 0.
- R9: Control bits under the mask 0x70FF_FFFE always read as 0. The other bits keep the value written to them.
- R10: A misaligned access has no effect on any register except the error status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| bus_sel | input | 1 | access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid in the cycle of the read |
| irq_rtc | output | 1 | clock group interrupt, level |
| irq_aerr | output | 1 | address-error interrupt, level |

## Verification
Read data is combinational, so the bench samples it one time unit after it drives a read on a falling edge, before the next rising edge. Writes and error flags take effect on the rising edge inside the access. The bench therefore reads results back, or samples the interrupt lines, only at the following falling edge. Second ticks arrive at a time the bench does not predict. Time checks first synchronise on the tick status bit by polling it, then act inside the tick period, and compare the tick position by its difference between two reads a known number of cycles apart.

// File: rtl/rtc_regblk_pkg.sv
// Package: register offsets, control constants and the decoded register
// selector shared by the block and its checker.
package rtc_regblk_pkg;

    localparam int unsigned OFS_TLOAD = 'h00;
    localparam int unsigned OFS_TNOW  = 'h04;
    localparam int unsigned OFS_CAL   = 'h08;
    localparam int unsigned OFS_TICK  = 'h0C;
    localparam int unsigned OFS_ALARM = 'h10;
    localparam int unsigned OFS_RSTAT = 'h14;
    localparam int unsigned OFS_RMASK = 'h18;
    localparam int unsigned OFS_REN   = 'h1C;
    localparam int unsigned OFS_RDIS  = 'h20;
    localparam int unsigned OFS_ASTAT = 'h24;
    localparam int unsigned OFS_AMASK = 'h28;
    localparam int unsigned OFS_AEN   = 'h2C;
    localparam int unsigned OFS_ADIS  = 'h30;
    localparam int unsigned OFS_CTRL  = 'h34;

    localparam logic [31:0] CTRL_RESET = 32'h0100_0000;
    localparam logic [31:0] CTRL_RSVD  = 32'h70FF_FFFE;

    typedef enum logic [3:0] {
        SEL_TLOAD, SEL_TNOW, SEL_CAL, SEL_TICK, SEL_ALARM,
        SEL_RSTAT, SEL_RMASK, SEL_REN, SEL_RDIS,
        SEL_ASTAT, SEL_AMASK, SEL_AEN, SEL_ADIS,
        SEL_CTRL, SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/rtc_prescaler.sv
// Prescaler: counts clock cycles and produces a one-cycle tick when the
// position reaches the divisor, then restarts at zero.
// Assumes: the divisor may change at any time. A position already above a
// newly lowered divisor ticks at once instead of wrapping through zero.
module rtc_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             tick_o
);
    logic [CNT_W-1:0] pos_q;

    // tick when the position has reached or passed the divisor
    always_comb tick_o = (pos_q >= div_i);

    // advance the position, restarting after each tick
    always_ff @(posedge clk) begin
        if (!rst_n)      pos_q <= '0;
        else if (tick_o) pos_q <= '0;
        else             pos_q <= pos_q + 1'b1;
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/rtc_seconds.sv
// Seconds counter: increments on each tick, or takes a staged load value on
// the first tick after it was written. It flags an alarm when the value
// taken at a tick equals the alarm register.
// Assumes: a load write in the same cycle as a tick waits for the next tick.
module rtc_seconds #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_wr_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] alarm_i,
    output logic [W-1:0] count_o,
    output logic         pend_o,
    output logic         alarm_hit_o
);
    logic [W-1:0] count_q, staged_q, next_val;
    logic         pend_q;

    // value the counter takes on the coming tick
    always_comb next_val = pend_q ? staged_q : count_q + 1'b1;

    // alarm fires on the tick that brings the count to the alarm value
    always_comb alarm_hit_o = tick_i && (next_val == alarm_i);

    // count update on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (tick_i) count_q <= next_val;
    end

    // staging of a load: a new write overrides the tick's clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            staged_q <= '0;
        end else if (load_wr_i) begin
            pend_q   <= 1'b1;
            staged_q <= load_val_i;
        end else if (tick_i) begin
            pend_q   <= 1'b0;
        end
    end

    assign count_o = count_q;
    assign pend_o  = pend_q;
endmodule

// File: rtl/rtc_irq_group.sv
// Interrupt group: status bits cleared by writing 1, with set events taking
// priority over a clear in the same cycle. The mask is changed only by the
// enable command (clears bits) and the disable command (sets bits). The
// level output is high when an unmasked status bit is set.
// Assumes: the mask resets to all ones and the status to zero.
module rtc_irq_group #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_stat_i,
    input  logic         wr_en_i,
    input  logic         wr_dis_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] stat_q, mask_q, clr;

    // bits cleared by a status write
    always_comb clr = wr_stat_i ? wdata_i : '0;

    // status register: write-one-to-clear, events set
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | set_i;
    end

    // mask register: changed only by the command strobes
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '1;
        else if (wr_en_i)  mask_q <= mask_q & ~wdata_i;
        else if (wr_dis_i) mask_q <= mask_q | wdata_i;
    end

    // level interrupt from unmasked pending bits
    always_comb irq_o = |(stat_q & ~mask_q);

    assign stat_o = stat_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/rtc_regblk.sv
// Real-time clock register block: decodes word accesses and holds the
// alarm, calibration and control registers. It connects the prescaler, the
// seconds counter and the two interrupt groups.
// Assumes: one access per cycle while bus_sel is high; reads are
// combinational; only accesses with address bits [1:0] = 0 are accepted.
module rtc_regblk
    import rtc_regblk_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              CAL_W     = 21,
    parameter int              TICK_W    = 16,
    parameter logic [CAL_W-1:0] CAL_RESET = 21'h00_7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_rtc,
    output logic              irq_aerr
);
    localparam int RTC_BITS = 2;

    reg_sel_e          sel_e;
    logic              wr_stb, bad_access;
    logic [31:0]       alarm_q, ctrl_q;
    logic [CAL_W-1:0]  calib_q;
    logic [TICK_W-1:0] tick_pos;
    logic              sec_tick, alarm_hit, load_pend;
    logic [31:0]       sec_count;
    logic [RTC_BITS-1:0] rtc_stat, rtc_mask;
    logic [0:0]        aerr_stat, aerr_mask;

    // address decode; misaligned or unmapped addresses select nothing
    always_comb begin
        sel_e = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            case (bus_addr)
                ADDR_W'(OFS_TLOAD): sel_e = SEL_TLOAD;
                ADDR_W'(OFS_TNOW):  sel_e = SEL_TNOW;
                ADDR_W'(OFS_CAL):   sel_e = SEL_CAL;
                ADDR_W'(OFS_TICK):  sel_e = SEL_TICK;
                ADDR_W'(OFS_ALARM): sel_e = SEL_ALARM;
                ADDR_W'(OFS_RSTAT): sel_e = SEL_RSTAT;
                ADDR_W'(OFS_RMASK): sel_e = SEL_RMASK;
                ADDR_W'(OFS_REN):   sel_e = SEL_REN;
                ADDR_W'(OFS_RDIS):  sel_e = SEL_RDIS;
                ADDR_W'(OFS_ASTAT): sel_e = SEL_ASTAT;
                ADDR_W'(OFS_AMASK): sel_e = SEL_AMASK;
                ADDR_W'(OFS_AEN):   sel_e = SEL_AEN;
                ADDR_W'(OFS_ADIS):  sel_e = SEL_ADIS;
                ADDR_W'(OFS_CTRL):  sel_e = SEL_CTRL;
                default:            sel_e = SEL_NONE;
            endcase
        end
    end

    // access qualifiers
    always_comb begin
        wr_stb     = bus_sel && bus_wr;
        bad_access = bus_sel && (sel_e == SEL_NONE);
    end

    // alarm, calibration and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            calib_q <= CAL_RESET;
            ctrl_q  <= CTRL_RESET;
        end else if (wr_stb) begin
            if (sel_e == SEL_ALARM) alarm_q <= bus_wdata;
            if (sel_e == SEL_CAL)   calib_q <= bus_wdata[CAL_W-1:0];
            if (sel_e == SEL_CTRL)  ctrl_q  <= bus_wdata & ~CTRL_RSVD;
        end
    end

    rtc_prescaler #(.CNT_W(TICK_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (calib_q[TICK_W-1:0]),
        .pos_o  (tick_pos),
        .tick_o (sec_tick)
    );

    rtc_seconds #(.W(32)) u_secs (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (sec_tick),
        .load_wr_i   (wr_stb && sel_e == SEL_TLOAD),
        .load_val_i  (bus_wdata),
        .alarm_i     (alarm_q),
        .count_o     (sec_count),
        .pend_o      (load_pend),
        .alarm_hit_o (alarm_hit)
    );

    rtc_irq_group #(.W(RTC_BITS)) u_rtc_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     ({alarm_hit, sec_tick}),
        .wr_stat_i (wr_stb && sel_e == SEL_RSTAT),
        .wr_en_i   (wr_stb && sel_e == SEL_REN),
        .wr_dis_i  (wr_stb && sel_e == SEL_RDIS),
        .wdata_i   (bus_wdata[RTC_BITS-1:0]),
        .stat_o    (rtc_stat),
        .mask_o    (rtc_mask),
        .irq_o     (irq_rtc)
    );

    rtc_irq_group #(.W(1)) u_aerr_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (bad_access),
        .wr_stat_i (wr_stb && sel_e == SEL_ASTAT),
        .wr_en_i   (wr_stb && sel_e == SEL_AEN),
        .wr_dis_i  (wr_stb && sel_e == SEL_ADIS),
        .wdata_i   (bus_wdata[0:0]),
        .stat_o    (aerr_stat),
        .mask_o    (aerr_mask),
        .irq_o     (irq_aerr)
    );

    // read data multiplexer; command registers read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (sel_e)
                SEL_TLOAD, SEL_TNOW: bus_rdata = sec_count;
                SEL_CAL:   bus_rdata = 32'(calib_q);
                SEL_TICK:  bus_rdata = 32'(tick_pos);
                SEL_ALARM: bus_rdata = alarm_q;
                SEL_RSTAT: bus_rdata = 32'(rtc_stat);
                SEL_RMASK: bus_rdata = 32'(rtc_mask);
                SEL_ASTAT: bus_rdata = 32'(aerr_stat);
                SEL_AMASK: bus_rdata = 32'(aerr_mask);
                SEL_CTRL:  bus_rdata = ctrl_q;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_regblk_checker.sv
// Checker: temporal properties of the register block, attached by bind.
module rtc_regblk_checker
    import rtc_regblk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [1:0]        rtc_stat,
    input logic [1:0]        rtc_mask,
    input logic [0:0]        aerr_stat,
    input logic              sec_tick,
    input logic              load_pend,
    input logic [31:0]       sec_count
);
    logic wr_cmd, wr_rstat, wr_tload;
    always_comb begin
        wr_cmd   = bus_sel && bus_wr &&
                   (bus_addr == ADDR_W'(OFS_REN) || bus_addr == ADDR_W'(OFS_RDIS));
        wr_rstat = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_RSTAT);
        wr_tload = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_TLOAD);
    end

    assert_mask_cmd_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rtc_mask) |-> $past(wr_cmd));

    assert_stat_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rtc_stat[0]) |-> $past(wr_rstat && bus_wdata[0]));

    assert_misaligned_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr[1:0] != 2'b00) |=> aerr_stat[0]);

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_pend) |=> sec_count == $past(sec_count) + 32'd1);

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(sec_count));

    assert_load_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && load_pend && !wr_tload) |=> !load_pend);
endmodule

bind rtc_regblk rtc_regblk_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rtc_stat  (rtc_stat),
    .rtc_mask  (rtc_mask),
    .aerr_stat (aerr_stat),
    .sec_tick  (sec_tick),
    .load_pend (load_pend),
    .sec_count (sec_count)
);

// File: tb/rtc_regblk_test.sv
module rtc_regblk_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DIV        = 9;   // tick every DIV+1 cycles

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_rtc, irq_aerr;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regblk #(.ADDR_W(ADDR_W), .CAL_RESET(21'(DIV))) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_rtc(irq_rtc), .irq_aerr(irq_aerr)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
        logic        chk;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h34, 32'h0,          32'h0100_0000, 4'd1,  1'b1}, // R1 control reset
        '{1'b0, 8'h18, 32'h0,          32'h3,         4'd1,  1'b1}, // R1 clock mask reset
        '{1'b0, 8'h28, 32'h0,          32'h1,         4'd1,  1'b1}, // R1 error mask reset
        '{1'b0, 8'h10, 32'h0,          32'h0,         4'd1,  1'b1}, // R1 alarm reset
        '{1'b1, 8'h34, 32'hFFFF_FFFF,  32'h0,         4'd9,  1'b0},
        '{1'b0, 8'h34, 32'h0,          32'h8F00_0001, 4'd9,  1'b1}, // R9 reserved read zero
        '{1'b1, 8'h34, 32'h0,          32'h0,         4'd9,  1'b0},
        '{1'b0, 8'h34, 32'h0,          32'h0,         4'd9,  1'b1}, // R9 writable bits clear
        '{1'b1, 8'h18, 32'h0,          32'h0,         4'd3,  1'b0},
        '{1'b0, 8'h18, 32'h0,          32'h3,         4'd3,  1'b1}, // R3 direct write ignored
        '{1'b1, 8'h1C, 32'h1,          32'h0,         4'd3,  1'b0},
        '{1'b0, 8'h18, 32'h0,          32'h2,         4'd3,  1'b1}, // R3 enable clears bit 0
        '{1'b0, 8'h1C, 32'h0,          32'h0,         4'd3,  1'b1}, // R3 command reads zero
        '{1'b1, 8'h20, 32'h3,          32'h0,         4'd3,  1'b0},
        '{1'b0, 8'h18, 32'h0,          32'h3,         4'd3,  1'b1}, // R3 disable sets bits
        '{1'b1, 8'h10, 32'hDEAD_BEEF,  32'h0,         4'd2,  1'b0},
        '{1'b0, 8'h10, 32'h0,          32'hDEAD_BEEF, 4'd2,  1'b1}, // R2 alarm readback
        '{1'b1, 8'h08, 32'hFFE0_0009,  32'h0,         4'd8,  1'b0},
        '{1'b0, 8'h08, 32'h0,          32'h0000_0009, 4'd8,  1'b1}, // R8 calibration width
        '{1'b1, 8'h11, 32'h1234_5678,  32'h0,         4'd10, 1'b0},
        '{1'b0, 8'h10, 32'h0,          32'hDEAD_BEEF, 4'd10, 1'b1}, // R10 misaligned write dropped
        '{1'b0, 8'h24, 32'h0,          32'h1,         4'd5,  1'b1}, // R5 flag from misaligned
        '{1'b1, 8'h24, 32'h0,          32'h0,         4'd5,  1'b0},
        '{1'b0, 8'h24, 32'h0,          32'h1,         4'd5,  1'b1}, // R5 write 0 keeps flag
        '{1'b1, 8'h24, 32'h1,          32'h0,         4'd5,  1'b0},
        '{1'b0, 8'h24, 32'h0,          32'h0,         4'd5,  1'b1}, // R5 write 1 clears
        '{1'b0, 8'h24, 32'h0,          32'h0,         4'd5,  1'b1}  // R5 stays clear
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // poll clock status until any bit of m is set; ok=0 on timeout
    task automatic poll_stat(input logic [31:0] m, output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            bus_read(8'h14, v);
            if ((v & m) != 0) begin ok = 1'b1; break; end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog got=timeout exp=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, a, b;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: interrupt outputs low out of reset
        check("R1 irq_rtc after reset", 32'(irq_rtc), 32'h0);
        check("R1 irq_aerr after reset", 32'(irq_aerr), 32'h0);

        // R8: tick position bounded and 16 bits wide
        bus_read(8'h0C, v);
        check("R8 tick position in range", 32'(v <= DIV), 32'h1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
            else begin
                bus_read(VECS[i].addr, v);
                if (VECS[i].chk)
                    check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // R5: error interrupt follows status and mask
        bus_write(8'h2C, 32'h1);
        check("R5 irq_aerr idle unmasked", 32'(irq_aerr), 32'h0);
        bus_read(8'hFC, v);
        check("R5 irq_aerr after unmapped read", 32'(irq_aerr), 32'h1);
        bus_write(8'h30, 32'h1);
        check("R5 irq_aerr masked again", 32'(irq_aerr), 32'h0);
        bus_write(8'h24, 32'h1);

        // R6: tick position advances 2 per two-cycle read, modulo DIV+1
        bus_read(8'h0C, a);
        bus_read(8'h0C, b);
        check("R6 tick step", (b + (DIV + 1) - a) % (DIV + 1), 32'd2);

        // R7: synchronise on a tick, load, then confirm at the next tick
        bus_write(8'h14, 32'h3);
        poll_stat(32'h1, ok);
        check("R2 tick sets status bit 0", 32'(ok), 32'h1);
        bus_write(8'h00, 32'd100);
        bus_write(8'h14, 32'h3);
        poll_stat(32'h1, ok);
        bus_read(8'h04, v);
        check("R7 load applied at tick", v, 32'd100);
        bus_read(8'h00, v);
        check("R7 load address reads count", v, 32'd100);
        bus_write(8'h14, 32'h3);
        poll_stat(32'h1, ok);
        bus_read(8'h04, v);
        check("R6 count increments", v, 32'd101);

        // R2: alarm at count 103
        bus_write(8'h10, 32'd103);
        poll_stat(32'h2, ok);
        check("R2 alarm status set", 32'(ok), 32'h1);
        bus_read(8'h04, v);
        check("R2 alarm at matching count", v, 32'd103);
        check("R4 irq_rtc low while masked", 32'(irq_rtc), 32'h0);
        bus_write(8'h1C, 32'h2);
        check("R4 irq_rtc high after enable", 32'(irq_rtc), 32'h1);
        bus_write(8'h14, 32'h0);
        bus_read(8'h14, v);
        check("R2 write 0 keeps alarm bit", v & 32'h2, 32'h2);
        bus_write(8'h14, 32'h2);
        check("R4 irq_rtc low after clear", 32'(irq_rtc), 32'h0);
        bus_read(8'h14, v);
        check("R2 write 1 clears alarm bit", v & 32'h2, 32'h0);
        bus_write(8'h20, 32'h3);
        bus_read(8'h18, v);
        check("R3 mask restored", v, 32'h3);

        finish_run();
    end
endmodule